// File: doc/BRIEF.md
# Symmetric Multiplierless FIR Filter

This block is a fixed-coefficient, linear-phase FIR filter that contains no multipliers. Each clock cycle it can accept one signed two's-complement sample, qualified by a valid strobe. It produces one filtered sample per accepted input, after a fixed latency. The coefficient set is symmetric, so the block adds each pair of mirrored taps before weighting them. Each distinct coefficient is supplied at elaboration as a canonical signed-digit pattern. Every nonzero digit turns into a hard-wired left shift of the pre-added operand, which is then added or subtracted. Zero digits cost no logic at all.

Registers split each coefficient's add/subtract chain. A coefficient with more nonzero digits gets more stages. Shorter chains are padded with plain registers, so that all partial products reaching the final adder belong to the same input sample. A delayed copy of the input strobe marks the output as valid. Changing the filter means re-elaborating with new digit patterns.

Top module: `fir_csd_sym`

## Requirements
- R1: For every accepted input x[n], the output equals sum over i=0..N-1 of h[i]*x[n-i] exactly, with h[i]=h[N-1-i]. Distinct coefficient k (k=0..ceil(N/2)-1) is given by CW-bit slice k of POS (digits of +2^b) and of NEG (digits of -2^b), where bit b stands for weight 2^b. The defaults are N=7 and h = -3, 7, 23, 45, 23, 7, -3.
- R2: After reset, samples older than the first accepted one are taken as zero. Data accepted before a reset never appears in a later result.
- R3: The delay line advances only in cycles with in_valid=1. Idle cycles, and the value of in_sample in those cycles, have no effect on any output.
- R4: When N is odd, the middle coefficient weights the middle tap exactly once. An isolated unit impulse therefore produces the seven defaults in order, with 45 appearing once.
- R5: Full-scale inputs (all 2047, all -2048, or alternating signs) give exact results with no wraparound. The output width is OW = IW + CW + clog2(N) + 2.
- R6: out_valid equals in_valid delayed by LAT = S+3 clock edges. S is the largest value of ceil(nonzero digits / TPS) over the coefficients, which gives LAT = 5 with the defaults.
- R7: out_sample changes only on an edge that raises or keeps out_valid. While out_valid is 0, out_sample holds its value.
- R8: While rst_n is low, out_valid and out_sample are 0, and all delay-line and pipeline state is cleared.
- R9: With in_valid held high, the block yields one new output on every clock once the pipeline has filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Marks in_sample as a new sample |
| in_sample | input | IW | Signed input sample |
| out_valid | output | 1 | Marks out_sample as a new result |
| out_sample | output | OW | Signed filtered result |

## Verification
A stale or shifted delay-line entry shows up as a wrong result at the first output that depends on it, LAT cycles after the sample that exposed it. An isolated impulse puts each coefficient on the port as its own output, so a bad digit, a wrong sign or a missing middle-tap special case is visible within seven outputs. A misbalanced pipeline stage mixes products from two different inputs. This is visible on any ramp or alternating pattern, and also moves the cycle in which out_valid rises. Saturated inputs expose a guard-bit shortage in the first full-scale window.

// File: rtl/fir_csd_pkg.sv
package fir_csd_pkg;
  localparam int MAX_DIGITS = 32;
  typedef logic [MAX_DIGITS-1:0] digit_mask_t;

  function automatic int nz_count(input digit_mask_t p, input digit_mask_t n);
    int c;
    c = 0;
    for (int i = 0; i < MAX_DIGITS; i++) if (p[i] || n[i]) c++;
    return c;
  endfunction

  // position of the m-th nonzero digit (0-based), -1 if none
  function automatic int nth_nz(input digit_mask_t p, input digit_mask_t n, input int m);
    int c;
    int r;
    c = 0;
    r = -1;
    for (int i = 0; i < MAX_DIGITS; i++) begin
      if (p[i] || n[i]) begin
        if (c == m && r < 0) r = i;
        c++;
      end
    end
    return r;
  endfunction

  function automatic longint csd_value(input digit_mask_t p, input digit_mask_t n);
    longint v;
    v = 0;
    for (int i = 0; i < MAX_DIGITS; i++) begin
      if (p[i]) v = v + (longint'(1) <<< i);
      if (n[i]) v = v - (longint'(1) <<< i);
    end
    return v;
  endfunction

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/fir_tapline.sv
module fir_tapline
  import fir_csd_pkg::*;
#(
  parameter int N  = 7,
  parameter int IW = 12,
  parameter int NH = (N + 1) / 2,
  parameter int PW = IW + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shift_en,
  input  logic signed [IW-1:0]   din,
  input  logic                   pre_en,
  output logic [NH*PW-1:0]       pre_q
);
  logic signed [IW-1:0] tap_q [N];
  logic signed [IW-1:0] tap_d [N];
  logic [NH*PW-1:0]     pre_d;

  always_comb begin
    tap_d = tap_q;
    if (shift_en) begin
      tap_d[0] = din;
      for (int i = 1; i < N; i++) tap_d[i] = tap_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) tap_q[i] <= '0;
    end else if (shift_en) begin
      tap_q <= tap_d;
    end
  end

  for (genvar k = 0; k < NH; k++) begin : g_pair
    if ((N % 2 == 1) && (k == NH - 1)) begin : g_mid
      assign pre_d[k*PW +: PW] = {tap_q[k][IW-1], tap_q[k]};
    end else begin : g_add
      assign pre_d[k*PW +: PW] = {tap_q[k][IW-1], tap_q[k]}
                               + {tap_q[N-1-k][IW-1], tap_q[N-1-k]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end
endmodule

// File: rtl/fir_csd_weight.sv
module fir_csd_weight
  import fir_csd_pkg::*;
#(
  parameter int PW  = 13,
  parameter int AW  = 25,
  parameter int CW  = 8,
  parameter int S   = 2,
  parameter int TPS = 2,
  parameter logic [CW-1:0] POS = '0,
  parameter logic [CW-1:0] NEG = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [S-1:0]         stage_en,
  input  logic signed [PW-1:0] op_in,
  output logic signed [AW-1:0] part_out
);
  localparam digit_mask_t PM = digit_mask_t'(POS);
  localparam digit_mask_t NM = digit_mask_t'(NEG);

  for (genvar j = 0; j < S; j++) begin : stg
    logic signed [AW-1:0] acc_in;
    logic signed [AW-1:0] acc_d;
    logic signed [AW-1:0] acc_q;
    logic signed [PW-1:0] op_cur;
    logic signed [AW-1:0] ext;
    int                   idx;

    if (j == 0) begin : g_first
      assign acc_in = '0;
      assign op_cur = op_in;
    end else begin : g_next
      assign acc_in = stg[j-1].acc_q;
      assign op_cur = stg[j-1].g_op.op_q;
    end

    // nonzero digits j*TPS .. j*TPS+TPS-1 are applied in this stage
    always_comb begin
      ext   = AW'(op_cur);
      acc_d = acc_in;
      for (int t = 0; t < TPS; t++) begin
        idx = nth_nz(PM, NM, j * TPS + t);
        if (idx >= 0) begin
          if (NEG[idx]) acc_d = acc_d - (ext <<< idx);
          else          acc_d = acc_d + (ext <<< idx);
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           acc_q <= '0;
      else if (stage_en[j]) acc_q <= acc_d;
    end

    if (j < S - 1) begin : g_op
      logic signed [PW-1:0] op_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           op_q <= '0;
        else if (stage_en[j]) op_q <= op_cur;
      end
    end
  end

  assign part_out = stg[S-1].acc_q;
endmodule

// File: rtl/fir_sum.sv
module fir_sum #(
  parameter int NH = 4,
  parameter int AW = 25
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [NH*AW-1:0]     parts,
  output logic signed [AW-1:0] sum_q
);
  logic signed [AW-1:0] sum_d;

  always_comb begin
    sum_d = '0;
    for (int k = 0; k < NH; k++) sum_d = sum_d + $signed(parts[k*AW +: AW]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sum_q <= '0;
    else if (en) sum_q <= sum_d;
  end
endmodule

// File: rtl/fir_csd_sym.sv
module fir_csd_sym
  import fir_csd_pkg::*;
#(
  parameter int N   = 7,
  parameter int IW  = 12,
  parameter int CW  = 8,
  parameter int TPS = 2,
  parameter logic [((N+1)/2)*CW-1:0] POS = {8'h41, 8'h20, 8'h08, 8'h01},
  parameter logic [((N+1)/2)*CW-1:0] NEG = {8'h14, 8'h09, 8'h01, 8'h04},
  parameter int OW  = IW + CW + $clog2(N) + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [IW-1:0] in_sample,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_sample
);
  localparam int NH = (N + 1) / 2;
  localparam int PW = IW + 1;

  function automatic int max_stages();
    int m;
    int s;
    m = 1;
    for (int k = 0; k < NH; k++) begin
      s = ceil_div(nz_count(digit_mask_t'(POS[k*CW +: CW]),
                            digit_mask_t'(NEG[k*CW +: CW])), TPS);
      if (s > m) m = s;
    end
    return m;
  endfunction

  localparam int S   = max_stages();
  localparam int LAT = S + 3;

  logic [S+2:0]     vq;
  logic [S+2:0]     vq_d;
  logic [NH*PW-1:0] pre;
  logic [NH*OW-1:0] parts;

  always_comb vq_d = {vq[S+1:0], in_valid};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vq <= '0;
    else        vq <= vq_d;
  end

  fir_tapline #(.N(N), .IW(IW), .NH(NH), .PW(PW)) u_taps (
    .clk(clk), .rst_n(rst_n), .shift_en(in_valid), .din(in_sample),
    .pre_en(vq[0]), .pre_q(pre)
  );

  for (genvar k = 0; k < NH; k++) begin : g_coef
    fir_csd_weight #(
      .PW(PW), .AW(OW), .CW(CW), .S(S), .TPS(TPS),
      .POS(POS[k*CW +: CW]), .NEG(NEG[k*CW +: CW])
    ) u_w (
      .clk(clk), .rst_n(rst_n), .stage_en(vq[S:1]),
      .op_in(pre[k*PW +: PW]), .part_out(parts[k*OW +: OW])
    );
  end

  fir_sum #(.NH(NH), .AW(OW)) u_sum (
    .clk(clk), .rst_n(rst_n), .en(vq[S+1]), .parts(parts), .sum_q(out_sample)
  );

  assign out_valid = vq[S+2];
endmodule

// File: rtl/fir_csd_sym_chk.sv
module fir_csd_sym_chk
  import fir_csd_pkg::*;
#(
  parameter int N   = 7,
  parameter int IW  = 12,
  parameter int CW  = 8,
  parameter int OW  = 25,
  parameter int LAT = 5,
  parameter logic [((N+1)/2)*CW-1:0] POS = '0,
  parameter logic [((N+1)/2)*CW-1:0] NEG = '0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic signed [OW-1:0] out_sample
);
  localparam int NH = (N + 1) / 2;

  function automatic longint peak_bound();
    longint b;
    longint v;
    b = 0;
    for (int k = 0; k < NH; k++) begin
      v = csd_value(digit_mask_t'(POS[k*CW +: CW]), digit_mask_t'(NEG[k*CW +: CW]));
      if (v < 0) v = -v;
      b = b + (((N % 2 == 1) && (k == NH - 1)) ? v : 2 * v);
    end
    return b * (longint'(1) <<< (IW - 1));
  endfunction

  localparam longint BOUND = peak_bound();

  logic [LAT-1:0] hist;
  int unsigned    in_cnt;
  int unsigned    out_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist    <= '0;
      in_cnt  <= '0;
      out_cnt <= '0;
    end else begin
      hist <= {hist[LAT-2:0], in_valid};
      if (in_valid)  in_cnt  <= in_cnt + 1;
      if (out_valid) out_cnt <= out_cnt + 1;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == hist[LAT-1]); // R6
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cnt < in_cnt)); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_sample)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((longint'(out_sample) <= BOUND) && (longint'(out_sample) >= -BOUND))); // R5
endmodule

bind fir_csd_sym fir_csd_sym_chk #(
  .N(N), .IW(IW), .CW(CW), .OW(OW), .LAT(LAT), .POS(POS), .NEG(NEG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .out_valid(out_valid), .out_sample(out_sample)
);

// File: tb/sim_fir_csd_sym.sv
module sim_fir_csd_sym;
  localparam int PERIOD = 10;
  localparam int N      = 7;
  localparam int IW     = 12;
  localparam int OW     = IW + 8 + 3 + 2;
  localparam int LAT    = 5;
  localparam int H [N]  = '{-3, 7, 23, 45, 23, 7, -3};
  // {valid, sample}
  localparam logic [IW:0] VEC [20] = '{
    13'h1005, 13'h1FFF, 13'h0ABC, 13'h1064, 13'h1F9C, 13'h1000, 13'h07FF,
    13'h17FF, 13'h1800, 13'h1123, 13'h0555, 13'h0321, 13'h1E00, 13'h1001,
    13'h1002, 13'h0FFF, 13'h1003, 13'h1ABC, 13'h1055, 13'h1F00};

  logic clk;
  logic rst_n;
  logic in_valid;
  logic signed [IW-1:0] in_sample;
  logic out_valid;
  logic signed [OW-1:0] out_sample;

  int checks, fails, cyc, outs_seen;
  longint hist [N];
  longint exp_v [$];
  int exp_c [$];
  string tag;
  logic signed [OW-1:0] last_out;
  bit done;
  longint ev;
  int ec;

  fir_csd_sym u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input longint act,
                       input longint expv, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) hist[i] = 0;
    exp_v.delete();
    exp_c.delete();
  endtask

  task automatic push(input bit v, input logic signed [IW-1:0] s);
    longint e;
    @(negedge clk);
    in_valid  = v;
    in_sample = s;
    if (v) begin
      for (int i = N - 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = longint'(s);
      e = 0;
      for (int i = 0; i < N; i++) e += longint'(H[i]) * hist[i];
      exp_v.push_back(e);
      exp_c.push_back(cyc + LAT);
    end
  endtask

  task automatic flush();
    for (int i = 0; i < LAT + 3; i++) push(1'b0, 12'sh5A5);
    check(exp_v.size() == 0, "R6", exp_v.size(), 0, "pending outputs after flush");
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    rst_n    = 1'b0;
    model_clear();
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R8", out_valid, 0, "out_valid in reset");
    check(out_sample == '0, "R8", out_sample, 0, "out_sample in reset");
    last_out = '0;
    rst_n    = 1'b1;
  endtask

  // output monitor: value, latency and hold checks
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        outs_seen++;
        if (exp_v.size() == 0) begin
          check(1'b0, "R6", 1, 0, "unexpected out_valid");
        end else begin
          ev = exp_v.pop_front();
          ec = exp_c.pop_front();
          check(cyc == ec, "R6", cyc, ec, "output cycle");
          check(longint'(out_sample) == ev, tag, longint'(out_sample), ev, "output value");
        end
      end else begin
        check(out_sample == last_out, "R7", longint'(out_sample), longint'(last_out),
              "hold while idle");
        if (exp_c.size() != 0 && exp_c[0] <= cyc) begin
          ec = exp_c.pop_front();
          ev = exp_v.pop_front();
          check(1'b0, "R6", cyc, ec, "missing output");
        end
      end
      last_out = out_sample;
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R6 watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; last_out = '0;
    tag = "R1";
    model_clear();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8", out_valid, 0, "out_valid at reset");
    check(out_sample == '0, "R8", out_sample, 0, "out_sample at reset");
    rst_n = 1'b1;

    // R1 / R3: table walk, mixed valid and idle entries
    tag = "R1";
    for (int i = 0; i < 20; i++) push(VEC[i][IW], VEC[i][IW-1:0]);
    flush();

    // R9: back-to-back ramp, one output per clock
    tag = "R9";
    outs_seen = 0;
    for (int i = 0; i < 12; i++) push(1'b1, 12'(i * 37 - 200));
    flush();
    check(outs_seen == 12, "R9", outs_seen, 12, "outputs for streaming run");

    // R4 / R2: impulse after reset reproduces the coefficient list
    do_reset();
    tag = "R4";
    push(1'b1, 12'sd1);
    for (int i = 0; i < N - 1; i++) push(1'b1, 12'sd0);
    flush();

    // R3: gaps with junk on the data input
    tag = "R3";
    for (int i = 0; i < 10; i++) begin
      push(1'b1, 12'(i * 113 - 500));
      push(1'b0, 12'sh7FF);
      if (i % 3 == 0) push(1'b0, 12'sh800);
    end
    flush();

    // R5: full-scale patterns
    tag = "R5";
    for (int i = 0; i < 8; i++) push(1'b1, 12'sd2047);
    for (int i = 0; i < 8; i++) push(1'b1, -12'sd2048);
    for (int i = 0; i < 8; i++) push(1'b1, (i % 2 == 0) ? 12'sd2047 : -12'sd2048);
    flush();

    // R2 / R8: reset mid-stream discards prior history and pending results
    tag = "R2";
    for (int i = 0; i < 4; i++) push(1'b1, 12'sd1000);
    do_reset();
    push(1'b1, 12'sd10);
    push(1'b1, 12'sd0);
    push(1'b1, 12'sd0);
    flush();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule